// File: doc/BRIEF.md
# Programmable Card Clock Divider

This block derives the card clock of a memory-card host from the peripheral clock. A 32-bit control word is written through a one-cycle write port. Two fields of that word steer the clock: a 4-bit exponent code selects a power-of-two divide, and a single enable bit gates the output. A bypass code passes the peripheral clock straight through, but only on systems that tie the bypass-support input high. Four 4-bit timeout fields share the word. The block does not use them; it stores them and drives them out to the command and data logic.

Next to the card clock, the block drives a strobe that is high for one peripheral-clock cycle just before each rising card-clock edge. Neighbouring logic can use it to launch or sample card data in the peripheral-clock domain. A new setting never cuts a high phase short. Divide changes are applied at the falling edge of the card clock, and a code the block cannot honour falls back to the slowest divide and raises a sticky flag.

Top module: `card_clk_gen`

## Requirements
- R1: A synchronous reset clears the control word and the sticky flag. After reset, `card_clk`, `rise_stb` and every timeout output are 0.
- R2: With bit 24 set and a code n from 0 to 8 in bits 19:16, the card clock period is 2^(n+1) peripheral cycles. When the clock is enabled from the disabled state, the first rising edge follows the write edge by 2^n+1 cycles.
- R3: In every divided setting the high phase and the low phase each last 2^n peripheral cycles.
- R4: While bit 24 is 0 once applied, `card_clk` stays low and `rise_stb` stays low.
- R5: Code 15 with bit 24 set and `bypass_ok` = 1 makes `card_clk` follow the peripheral clock and holds `rise_stb` at 1. `bad_setting` stays 0.
- R6: Codes 9 to 14, and code 15 while `bypass_ok` = 0, divide by 512 and set `bad_setting` one cycle after the write. Only reset clears the flag, and a later legal write leaves it set.
- R7: A new setting written while the card clock is high or low in divided mode takes effect at the next falling edge, so the current high phase completes at its old length. When the clock is disabled or bypassed, the new setting applies on the next cycle.
- R8: In divided mode, `rise_stb` is 1 in exactly the peripheral cycle before each rising edge of `card_clk`.
- R9: The timeout outputs show bits 15:12 (`tmo_resp`), 11:8 (`tmo_busy`), 7:4 (`tmo_rdwr`) and 3:0 (`tmo_done`) of the last written word, one cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word to store |
| bypass_ok | input | 1 | Tied high where undivided bypass is supported |
| card_clk | output | 1 | Card clock |
| rise_stb | output | 1 | High in the cycle before a card clock rising edge |
| bad_setting | output | 1 | Sticky flag for an unsupported divide code |
| tmo_resp | output | 4 | Stored response timeout field |
| tmo_busy | output | 4 | Stored busy timeout field |
| tmo_rdwr | output | 4 | Stored read/write timeout field |
| tmo_done | output | 4 | Stored completion-signal timeout field |

## Verification
A register write and a falling edge of the card clock can fall in the same place in time. The case of interest is a write that arrives while the clock is high, where the new divide is held back until the fall. The bench writes a faster code in the first high cycle of a /16 clock and counts the samples until the fall, which must total eight. It then checks that the next full period has the new length, 2. A disable written in mid-high is judged the same way: the high phase completes in full, and after that the clock stays low with no strobe.

// File: rtl/mclk_pkg.sv
package mclk_pkg;
  localparam int WORD_W  = 32;
  localparam int CODE_W  = 4;
  localparam int MAX_EXP = 8;
  localparam int CNT_W   = MAX_EXP;
  localparam int SEL_LSB = 16;
  localparam int EN_BIT  = 24;
  localparam int TMO_W   = 4;
  localparam logic [CODE_W-1:0] BYP_CODE = '1;

  typedef struct packed {
    logic              en;
    logic              byp;
    logic              bad;
    logic [CODE_W-1:0] expo;
  } mode_t;

  // Turn a control word into an applied clock mode.
  function automatic mode_t decode_mode(logic [WORD_W-1:0] word, logic byp_ok);
    mode_t m;
    logic [CODE_W-1:0] code;
    code   = word[SEL_LSB +: CODE_W];
    m.en   = word[EN_BIT];
    m.byp  = 1'b0;
    m.bad  = 1'b0;
    m.expo = CODE_W'(MAX_EXP);
    if (code <= CODE_W'(MAX_EXP)) begin
      m.expo = code;
    end else if (code == BYP_CODE && byp_ok) begin
      m.byp = m.en;
    end else begin
      m.bad = 1'b1;
    end
    return m;
  endfunction

  // Last count of a half period that lasts 2^expo cycles.
  function automatic logic [CNT_W-1:0] half_limit(logic [CODE_W-1:0] expo);
    logic [CNT_W:0] span;
    span = (CNT_W+1)'(1) << expo;
    return CNT_W'(span - 1'b1);
  endfunction
endpackage

// File: rtl/mclk_ctl_reg.sv
module mclk_ctl_reg
  import mclk_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              bypass_ok,
  output logic [WORD_W-1:0] ctl_word,
  output mode_t             want_mode,
  output logic              bad_flag
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_word <= '0;
    end else if (wr_en) begin
      ctl_word <= wr_data;
    end
  end

  assign want_mode = decode_mode(ctl_word, bypass_ok);

  always_ff @(posedge clk) begin
    if (rst) begin
      bad_flag <= 1'b0;
    end else begin
      bad_flag <= bad_flag | want_mode.bad;
    end
  end
endmodule

// File: rtl/mclk_div_core.sv
module mclk_div_core
  import mclk_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  mode_t want_mode,
  output mode_t act_mode,
  output logic  div_q,
  output logic  load_now,
  output logic  rise_next
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;
  logic             at_end;

  assign lim       = half_limit(act_mode.expo);
  assign at_end    = (cnt == lim);
  // Settings are taken while idle, bypassed, or at the card clock fall.
  assign load_now  = !act_mode.en || act_mode.byp || (div_q && at_end);
  assign rise_next = act_mode.byp || (act_mode.en && !div_q && at_end);

  always_ff @(posedge clk) begin
    if (rst) begin
      act_mode <= '0;
      cnt      <= '0;
      div_q    <= 1'b0;
    end else if (load_now) begin
      act_mode <= want_mode;
      cnt      <= '0;
      div_q    <= 1'b0;
    end else if (at_end) begin
      cnt      <= '0;
      div_q    <= ~div_q;
    end else begin
      cnt      <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mclk_out_sel.sv
module mclk_out_sel (
  input  logic clk,
  input  logic rst,
  input  logic byp_req,
  input  logic div_q,
  output logic card_clk
);
  logic byp_sel;

  // Select changes only while clk is low and the divided clock is low.
  always_ff @(negedge clk) begin
    if (rst) begin
      byp_sel <= 1'b0;
    end else begin
      byp_sel <= byp_req;
    end
  end

  assign card_clk = byp_sel ? clk : div_q;
endmodule

// File: rtl/card_clk_gen.sv
module card_clk_gen
  import mclk_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              bypass_ok,
  output logic              card_clk,
  output logic              rise_stb,
  output logic              bad_setting,
  output logic [TMO_W-1:0]  tmo_resp,
  output logic [TMO_W-1:0]  tmo_busy,
  output logic [TMO_W-1:0]  tmo_rdwr,
  output logic [TMO_W-1:0]  tmo_done
);
  logic [WORD_W-1:0] ctl_word;
  mode_t             want_mode;
  mode_t             act_mode;
  logic              div_q;
  logic              load_now;
  logic              rise_next;
  logic              act_en;
  logic              act_byp;
  logic [CODE_W-1:0] act_exp;

  mclk_ctl_reg u_reg (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .bypass_ok (bypass_ok),
    .ctl_word  (ctl_word),
    .want_mode (want_mode),
    .bad_flag  (bad_setting)
  );

  mclk_div_core u_div (
    .clk       (clk),
    .rst       (rst),
    .want_mode (want_mode),
    .act_mode  (act_mode),
    .div_q     (div_q),
    .load_now  (load_now),
    .rise_next (rise_next)
  );

  mclk_out_sel u_sel (
    .clk      (clk),
    .rst      (rst),
    .byp_req  (act_mode.byp),
    .div_q    (div_q),
    .card_clk (card_clk)
  );

  assign act_en   = act_mode.en;
  assign act_byp  = act_mode.byp;
  assign act_exp  = act_mode.expo;
  assign rise_stb = rise_next;

  generate
    for (genvar f = 0; f < 4; f++) begin : g_tmo
      localparam int LSB = (3 - f) * TMO_W;
      logic [TMO_W-1:0] fld;
      assign fld = ctl_word[LSB +: TMO_W];
    end
  endgenerate

  assign tmo_resp = g_tmo[0].fld;
  assign tmo_busy = g_tmo[1].fld;
  assign tmo_rdwr = g_tmo[2].fld;
  assign tmo_done = g_tmo[3].fld;
endmodule

// File: rtl/card_clk_gen_chk.sv
module card_clk_gen_chk (
  input logic        clk,
  input logic        rst,
  input logic        wr_en,
  input logic [31:0] wr_data,
  input logic        div_q,
  input logic        rise_stb,
  input logic        bad_setting,
  input logic        act_en,
  input logic        act_byp,
  input logic [3:0]  act_exp,
  input logic [3:0]  tmo_resp,
  input logic [3:0]  tmo_done
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!div_q && !rise_stb && !bad_setting));

  p_off_low_r4: assert property (@(posedge clk) disable iff (rst)
    !act_en |-> (!div_q && !rise_stb));

  p_byp_div_idle_r5: assert property (@(posedge clk) disable iff (rst)
    act_byp |-> !div_q);

  p_flag_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    bad_setting |=> bad_setting);

  p_hold_while_high_r7: assert property (@(posedge clk) disable iff (rst)
    div_q |=> (!div_q || ($stable(act_exp) && $stable(act_en) && $stable(act_byp))));

  p_stb_then_rise_r8: assert property (@(posedge clk) disable iff (rst)
    (rise_stb && !act_byp) |=> $rose(div_q));

  p_tmo_follow_r9: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (tmo_resp == $past(wr_data[15:12]) && tmo_done == $past(wr_data[3:0])));
endmodule

bind card_clk_gen card_clk_gen_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .wr_en       (wr_en),
  .wr_data     (wr_data),
  .div_q       (div_q),
  .rise_stb    (rise_stb),
  .bad_setting (bad_setting),
  .act_en      (act_en),
  .act_byp     (act_byp),
  .act_exp     (act_exp),
  .tmo_resp    (tmo_resp),
  .tmo_done    (tmo_done)
);

// File: tb/test_card_clk_gen.sv
`timescale 1ns/1ps
module test_card_clk_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        bypass_ok = 1'b0;
  logic        card_clk, rise_stb, bad_setting;
  logic [3:0]  tmo_resp, tmo_busy, tmo_rdwr, tmo_done;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  card_clk_gen i_card_clk_gen (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .bypass_ok(bypass_ok),
    .card_clk(card_clk), .rise_stb(rise_stb), .bad_setting(bad_setting),
    .tmo_resp(tmo_resp), .tmo_busy(tmo_busy), .tmo_rdwr(tmo_rdwr), .tmo_done(tmo_done)
  );

  always #4 clk = ~clk;

  localparam int NV = 9;
  localparam int V_CODE [NV] = '{0, 1, 2, 3, 5, 8, 9, 14, 15};
  localparam int V_HALF [NV] = '{1, 2, 4, 8, 32, 256, 256, 256, 256};
  localparam int V_BAD  [NV] = '{0, 0, 0, 0, 0, 0, 1, 1, 1};

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    tick();
    tick();
    rst = 1'b0;
  endtask

  task automatic write(input logic [31:0] w);
    wr_data = w;
    wr_en = 1'b1;
    tick();
    wr_en = 1'b0;
  endtask

  function automatic logic [31:0] ctl(input bit en, input int code, input logic [15:0] tmo);
    return {7'b0, en, 4'b0, 4'(code), tmo};
  endfunction

  task automatic shape(output int hi, output int lo, output bit stb_ok);
    int guard;
    logic prev_s;
    hi = 0; lo = 0; stb_ok = 1; guard = 0;
    while (card_clk !== 1'b0 && guard < 4000) begin tick(); guard++; end
    prev_s = rise_stb;
    while (card_clk !== 1'b1 && guard < 4000) begin prev_s = rise_stb; tick(); guard++; end
    if (prev_s !== 1'b1) stb_ok = 0;
    while (card_clk === 1'b1 && guard < 4000) begin hi++; tick(); guard++; end
    prev_s = 1'b0;
    while (card_clk === 1'b0 && guard < 4000) begin lo++; prev_s = rise_stb; tick(); guard++; end
    if (prev_s !== 1'b1) stb_ok = 0;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int hi, lo, k;
    bit sok;
    bit seen;

    // R1 reset state
    do_reset();
    check(card_clk === 1'b0 && rise_stb === 1'b0, "R1 clock and strobe after reset", card_clk, 0);
    check(bad_setting === 1'b0, "R1 flag after reset", bad_setting, 0);
    check({tmo_resp, tmo_busy, tmo_rdwr, tmo_done} === 16'h0, "R1 timeouts after reset",
          {tmo_resp, tmo_busy, tmo_rdwr, tmo_done}, 0);

    // Table walk: R2 latency, R3 duty, R8 strobe, R6 fallback
    for (int v = 0; v < NV; v++) begin
      bypass_ok = 1'b0;
      do_reset();
      write(ctl(1'b1, V_CODE[v], 16'h2FFF));
      k = 0;
      while (card_clk !== 1'b1 && k < 2000) begin tick(); k++; end
      check(k == V_HALF[v] + 1, $sformatf("R2 first rise latency code %0d", V_CODE[v]), k, V_HALF[v] + 1);
      shape(hi, lo, sok);
      check(hi == V_HALF[v], $sformatf("R3 high length code %0d", V_CODE[v]), hi, V_HALF[v]);
      check(lo == V_HALF[v], $sformatf("R3 low length code %0d", V_CODE[v]), lo, V_HALF[v]);
      check(sok, $sformatf("R8 strobe before rise code %0d", V_CODE[v]), sok, 1);
      check(bad_setting === 1'(V_BAD[v]), $sformatf("R6 flag code %0d", V_CODE[v]), bad_setting, V_BAD[v]);
    end

    // R6 sticky across a legal write, then R1 reset clears it
    write(ctl(1'b1, 0, 16'h0));
    tick();
    check(bad_setting === 1'b1, "R6 flag stays after legal write", bad_setting, 1);
    do_reset();
    check(bad_setting === 1'b0, "R1 reset clears flag", bad_setting, 0);

    // R9 timeout fields
    write(ctl(1'b0, 2, 16'hA5C3));
    check(tmo_resp === 4'hA && tmo_busy === 4'h5, "R9 resp and busy fields",
          {tmo_resp, tmo_busy}, 8'hA5);
    check(tmo_rdwr === 4'hC && tmo_done === 4'h3, "R9 rdwr and done fields",
          {tmo_rdwr, tmo_done}, 8'hC3);

    // R4 disabled: code present but enable bit clear
    seen = 0;
    for (int i = 0; i < 100; i++) begin
      if (card_clk !== 1'b0 || rise_stb !== 1'b0) seen = 1;
      tick();
    end
    check(!seen, "R4 disabled clock stays low", seen, 0);

    // R5 bypass
    bypass_ok = 1'b1;
    write(ctl(1'b1, 15, 16'h0));
    tick(); tick(); tick();
    check(card_clk === 1'b1 && rise_stb === 1'b1, "R5 bypass high half", card_clk, 1);
    #4;
    check(card_clk === 1'b0, "R5 bypass low half", card_clk, 0);
    #2;
    check(bad_setting === 1'b0, "R5 no flag with bypass support", bad_setting, 0);

    // R7 leaving bypass applies next cycle: /2
    write(ctl(1'b1, 0, 16'h0));
    tick();
    shape(hi, lo, sok);
    check(hi == 1 && lo == 1, "R7 bypass exit to divide by 2", hi * 10 + lo, 11);

    // R7 change while high: old high phase completes
    bypass_ok = 1'b0;
    do_reset();
    write(ctl(1'b1, 3, 16'h0));
    k = 0;
    while (card_clk !== 1'b1 && k < 100) begin tick(); k++; end
    hi = 1;
    write(ctl(1'b1, 0, 16'h0));
    while (card_clk === 1'b1 && hi < 100) begin hi++; tick(); end
    check(hi == 8, "R7 high phase kept at old length", hi, 8);
    shape(hi, lo, sok);
    check(hi == 1 && lo == 1 && sok, "R7 new divide after fall", hi * 10 + lo, 11);

    // R4 and R7 disable while high
    write(ctl(1'b1, 2, 16'h0));
    tick(); tick(); tick();
    k = 0;
    while (card_clk !== 1'b1 && k < 100) begin tick(); k++; end
    hi = 1;
    write(ctl(1'b0, 2, 16'h0));
    while (card_clk === 1'b1 && hi < 100) begin hi++; tick(); end
    check(hi == 4, "R7 disable waits for fall", hi, 4);
    seen = 0;
    for (int i = 0; i < 60; i++) begin
      if (card_clk !== 1'b0 || rise_stb !== 1'b0) seen = 1;
      tick();
    end
    check(!seen, "R4 held low after disable", seen, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule